// File: doc/BRIEF.md
# Pixel-Rate Colour Channel Sequencer

This block drives the colour select of a three-colour image-sensor front end, one decision per ADC sample clock. Every conversion is tagged with the colour it belongs to, and the gain and offset codes for that colour are presented alongside. A pixel begins at the first rising ADC clock edge that sees the data-sample clock low after it was high. In three-channel mode the block then walks through red, green and blue in one of six programmable orders, one colour per ADC clock. In single-channel mode it parks on one chosen colour for the whole pixel.

The mode field and the colour-index field are captured only at a pixel start. Software can therefore rewrite them at any time without tearing a pixel. The per-colour gain and offset registers are read live. The codes for each conversion come from the register values present at that conversion's clock edge.

Top module: `pixel_colour_sequencer`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release takes effect, chan_sel_o is 0, pixel_start_o is 0, and coarse_gain_o, fine_gain_o and offset_o are all zero. Channel codes are red=0, green=1 and blue=2.
- R2: A pixel starts on the clock edge at which data_clk_i is sampled low while the previous sample was high. After reset the previous sample counts as low. pixel_start_o is high for exactly the cycle that follows that edge.
- R3: In three-channel mode, colour_index_i[4:2] selects the order of colours: 000 R,G,B; 001 R,B,G; 010 G,R,B; 011 G,B,R; 100 B,R,G; 101 B,G,R. chan_sel_o shows the first colour after the start edge, the second after the next edge and the third after the one after that.
- R4: Once the third colour is shown, chan_sel_o holds it until the next pixel start.
- R5: The order codes 110 and 111 behave as R,G,B.
- R6: When chan_mode_i is 01, the block is in single-channel mode. colour_index_i[1:0] then picks one colour for the whole pixel: 00 red, 01 green, 10 blue, and 11 treated as red.
- R7: Every chan_mode_i value other than 01 (00, 10, 11) selects three-channel mode.
- R8: chan_mode_i and colour_index_i are captured only on a pixel start edge. A change at any other time has no effect until the next pixel start. A value present on the start edge itself applies to that pixel.
- R9: On every clock edge after reset, the registered outputs are loaded from the live registers of the colour that chan_sel_o takes at that edge: coarse_gain_o from gain bits [6:5], fine_gain_o from gain bits [4:0], and offset_o from the full 8-bit offset.
- R10: A pixel start that arrives before three colours have been converted abandons the sequence and restarts at the first colour of the newly captured order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_adc | input | 1 | ADC sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| data_clk_i | input | 1 | Data-sample clock level; a high-to-low change marks a pixel |
| chan_mode_i | input | 2 | Channel mode field; 01 single-channel, others three-channel |
| colour_index_i | input | 5 | [4:2] three-colour order, [1:0] single colour |
| gain_red_i | input | 7 | Red gain register: [6:5] coarse, [4:0] fine |
| gain_grn_i | input | 7 | Green gain register |
| gain_blu_i | input | 7 | Blue gain register |
| off_red_i | input | 8 | Red offset register |
| off_grn_i | input | 8 | Green offset register |
| off_blu_i | input | 8 | Blue offset register |
| chan_sel_o | output | 2 | Colour of the current conversion |
| coarse_gain_o | output | 2 | Coarse gain code for that colour |
| fine_gain_o | output | 5 | Fine gain code for that colour |
| offset_o | output | 8 | Offset code for that colour |
| pixel_start_o | output | 1 | High on the first conversion of each pixel |

## Verification
Two events can fall on the same edge: a pixel start, and a step advance or a register rewrite. The bench provokes the first case with pixels short enough that the data clock falls again after only one or two conversions. On that edge the sequence must restart at the new first colour rather than advance. It provokes the second case by rewriting the colour index on the very cycle of the start edge, where the new value must apply to that pixel, and one cycle later, where it must wait a full pixel. A reference model built from the requirements predicts each cycle's select and codes into a queue, and a monitor compares them after every edge.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int NUM_COL = 3;
  localparam int STEP_W  = $clog2(NUM_COL);

  typedef enum logic [1:0] {
    COL_RED = 2'd0,
    COL_GRN = 2'd1,
    COL_BLU = 2'd2
  } colour_e;

  localparam logic [1:0] MODE_SINGLE = 2'b01;

  // colour at a given step of a three-colour order code
  function automatic colour_e order_pick(input logic [2:0] ord, input logic [STEP_W-1:0] step);
    logic [5:0] seq;
    case (ord)
      3'd1:    seq = {COL_RED, COL_BLU, COL_GRN};
      3'd2:    seq = {COL_GRN, COL_RED, COL_BLU};
      3'd3:    seq = {COL_GRN, COL_BLU, COL_RED};
      3'd4:    seq = {COL_BLU, COL_RED, COL_GRN};
      3'd5:    seq = {COL_BLU, COL_GRN, COL_RED};
      default: seq = {COL_RED, COL_GRN, COL_BLU};
    endcase
    case (step)
      2'd0:    return colour_e'(seq[5:4]);
      2'd1:    return colour_e'(seq[3:2]);
      default: return colour_e'(seq[1:0]);
    endcase
  endfunction

  function automatic colour_e single_pick(input logic [1:0] code);
    case (code)
      2'd1:    return COL_GRN;
      2'd2:    return COL_BLU;
      default: return COL_RED;
    endcase
  endfunction

endpackage

// File: rtl/pcs_boundary_det.sv
module pcs_boundary_det (
  input  logic clk,
  input  logic rst_n,
  input  logic data_clk_i,
  output logic boundary_o
);

  logic dclk_q;
  logic dclk_d;

  always_comb begin
    dclk_d = data_clk_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dclk_q <= 1'b0;
    else        dclk_q <= dclk_d;
  end

  assign boundary_o = dclk_q & ~data_clk_i;

endmodule

// File: rtl/pcs_step_ctrl.sv
module pcs_step_ctrl
  import pcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boundary_i,
  input  logic [1:0] chan_mode_i,
  input  logic [4:0] colour_index_i,
  output colour_e    sel_next_o,
  output colour_e    sel_o,
  output logic       first_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_COL - 1);

  logic              single_q, single_d;
  logic [2:0]        order_q, order_d;
  logic [1:0]        scol_q, scol_d;
  logic              active_q, active_d;
  logic [STEP_W-1:0] step_q, step_d;
  colour_e           sel_q, sel_d;
  logic              first_q, first_d;
  logic              shadow_en;

  assign shadow_en = boundary_i;

  always_comb begin
    single_d = single_q;
    order_d  = order_q;
    scol_d   = scol_q;
    active_d = active_q;
    step_d   = step_q;
    first_d  = boundary_i;
    if (shadow_en) begin
      single_d = (chan_mode_i == MODE_SINGLE);
      order_d  = colour_index_i[4:2];
      scol_d   = colour_index_i[1:0];
      active_d = 1'b1;
      step_d   = '0;
    end else if (active_q && (step_q != LAST_STEP)) begin
      step_d = step_q + 1'b1;
    end
    if (!active_d)     sel_d = COL_RED;
    else if (single_d) sel_d = single_pick(scol_d);
    else               sel_d = order_pick(order_d, step_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q <= 1'b0;
      order_q  <= '0;
      scol_q   <= '0;
      active_q <= 1'b0;
      step_q   <= '0;
      sel_q    <= COL_RED;
      first_q  <= 1'b0;
    end else begin
      if (shadow_en) begin
        single_q <= single_d;
        order_q  <= order_d;
        scol_q   <= scol_d;
      end
      active_q <= active_d;
      step_q   <= step_d;
      sel_q    <= sel_d;
      first_q  <= first_d;
    end
  end

  assign sel_next_o = sel_d;
  assign sel_o      = sel_q;
  assign first_o    = first_q;

  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP);

  assert_hold_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !boundary_i && step_q == LAST_STEP) |=> $stable(sel_q));

  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> $stable({single_q, order_q, scol_q}));

  assert_single_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && single_q && !boundary_i) |=> $stable(sel_q));

endmodule

// File: rtl/pcs_code_mux.sv
module pcs_code_mux
  import pcs_pkg::*;
#(
  parameter int COARSE_W = 2,
  parameter int FINE_W   = 5,
  parameter int OFF_W    = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  colour_e                               sel_i,
  input  logic [NUM_COL*(COARSE_W+FINE_W)-1:0]  gain_flat_i,
  input  logic [NUM_COL*OFF_W-1:0]              off_flat_i,
  output logic [COARSE_W-1:0]                   coarse_o,
  output logic [FINE_W-1:0]                     fine_o,
  output logic [OFF_W-1:0]                      offset_o
);

  localparam int GAIN_W = COARSE_W + FINE_W;

  logic [GAIN_W-1:0] gain_tab [NUM_COL];
  logic [OFF_W-1:0]  off_tab  [NUM_COL];

  for (genvar c = 0; c < NUM_COL; c++) begin : g_tab
    assign gain_tab[c] = gain_flat_i[c*GAIN_W +: GAIN_W];
    assign off_tab[c]  = off_flat_i[c*OFF_W +: OFF_W];
  end

  logic [GAIN_W-1:0]   gain_d;
  logic [OFF_W-1:0]    off_d;
  logic [COARSE_W-1:0] coarse_q;
  logic [FINE_W-1:0]   fine_q;
  logic [OFF_W-1:0]    off_q;

  always_comb begin
    case (sel_i)
      COL_GRN: begin gain_d = gain_tab[1]; off_d = off_tab[1]; end
      COL_BLU: begin gain_d = gain_tab[2]; off_d = off_tab[2]; end
      default: begin gain_d = gain_tab[0]; off_d = off_tab[0]; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
      fine_q   <= '0;
      off_q    <= '0;
    end else begin
      coarse_q <= gain_d[GAIN_W-1:FINE_W];
      fine_q   <= gain_d[FINE_W-1:0];
      off_q    <= off_d;
    end
  end

  assign coarse_o = coarse_q;
  assign fine_o   = fine_q;
  assign offset_o = off_q;

  assert_sel_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i != 2'd3);

endmodule

// File: rtl/pixel_colour_sequencer.sv
module pixel_colour_sequencer
  import pcs_pkg::*;
#(
  parameter int COARSE_W = 2,
  parameter int FINE_W   = 5,
  parameter int OFF_W    = 8
) (
  input  logic                         clk_adc,
  input  logic                         rst_n,
  input  logic                         data_clk_i,
  input  logic [1:0]                   chan_mode_i,
  input  logic [4:0]                   colour_index_i,
  input  logic [COARSE_W+FINE_W-1:0]   gain_red_i,
  input  logic [COARSE_W+FINE_W-1:0]   gain_grn_i,
  input  logic [COARSE_W+FINE_W-1:0]   gain_blu_i,
  input  logic [OFF_W-1:0]             off_red_i,
  input  logic [OFF_W-1:0]             off_grn_i,
  input  logic [OFF_W-1:0]             off_blu_i,
  output logic [1:0]                   chan_sel_o,
  output logic [COARSE_W-1:0]          coarse_gain_o,
  output logic [FINE_W-1:0]            fine_gain_o,
  output logic [OFF_W-1:0]             offset_o,
  output logic                         pixel_start_o
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_adc or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  logic    boundary;
  colour_e sel_next;
  colour_e sel_cur;

  pcs_boundary_det u_det (
    .clk        (clk_adc),
    .rst_n      (rst_int_n),
    .data_clk_i (data_clk_i),
    .boundary_o (boundary)
  );

  pcs_step_ctrl u_step (
    .clk            (clk_adc),
    .rst_n          (rst_int_n),
    .boundary_i     (boundary),
    .chan_mode_i    (chan_mode_i),
    .colour_index_i (colour_index_i),
    .sel_next_o     (sel_next),
    .sel_o          (sel_cur),
    .first_o        (pixel_start_o)
  );

  pcs_code_mux #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W),
    .OFF_W    (OFF_W)
  ) u_codes (
    .clk         (clk_adc),
    .rst_n       (rst_int_n),
    .sel_i       (sel_next),
    .gain_flat_i ({gain_blu_i, gain_grn_i, gain_red_i}),
    .off_flat_i  ({off_blu_i, off_grn_i, off_red_i}),
    .coarse_o    (coarse_gain_o),
    .fine_o      (fine_gain_o),
    .offset_o    (offset_o)
  );

  assign chan_sel_o = sel_cur;

  assert_start_on_edge_R2: assert property (@(posedge clk_adc) disable iff (!rst_int_n)
    boundary |=> pixel_start_o);

  assert_start_only_edge_R2: assert property (@(posedge clk_adc) disable iff (!rst_int_n)
    !boundary |=> !pixel_start_o);

  assert_restart_rgb_R10: assert property (@(posedge clk_adc) disable iff (!rst_int_n)
    (boundary && chan_mode_i != MODE_SINGLE && colour_index_i[4:3] != 2'b10
     && colour_index_i[4:2] != 3'b001 && colour_index_i[4:2] != 3'b000
     && colour_index_i[4] == 1'b1) |=> chan_sel_o == 2'd0);

endmodule

// File: tb/pixel_colour_sequencer_bench.sv
module pixel_colour_sequencer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       data_clk;
  logic [1:0] chan_mode;
  logic [4:0] cidx;
  logic [6:0] g_r, g_g, g_b;
  logic [7:0] o_r, o_g, o_b;
  logic [1:0] sel;
  logic [1:0] coarse;
  logic [4:0] fine;
  logic [7:0] offs;
  logic       pstart;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pixel_colour_sequencer u_pixel_colour_sequencer (
    .clk_adc        (clk),
    .rst_n          (rst_n),
    .data_clk_i     (data_clk),
    .chan_mode_i    (chan_mode),
    .colour_index_i (cidx),
    .gain_red_i     (g_r),
    .gain_grn_i     (g_g),
    .gain_blu_i     (g_b),
    .off_red_i      (o_r),
    .off_grn_i      (o_g),
    .off_blu_i      (o_b),
    .chan_sel_o     (sel),
    .coarse_gain_o  (coarse),
    .fine_gain_o    (fine),
    .offset_o       (offs),
    .pixel_start_o  (pstart)
  );

  // expected item packed as {sel, start, coarse, fine, offset}
  logic [17:0] exp_q [$];
  string       tag_q [$];
  string       cur_tag;

  // reference model state
  logic       m_prev = 1'b0;
  logic       m_act  = 1'b0;
  logic       m_single = 1'b0;
  logic [2:0] m_order = 3'd0;
  logic [1:0] m_sc = 2'd0;
  int         m_step = 0;

  function automatic logic [1:0] ref_order(input logic [2:0] o, input int s);
    logic [1:0] a, b, c;
    case (o)
      3'd1: begin a = 0; b = 2; c = 1; end
      3'd2: begin a = 1; b = 0; c = 2; end
      3'd3: begin a = 1; b = 2; c = 0; end
      3'd4: begin a = 2; b = 0; c = 1; end
      3'd5: begin a = 2; b = 1; c = 0; end
      default: begin a = 0; b = 1; c = 2; end
    endcase
    return (s == 0) ? a : (s == 1) ? b : c;
  endfunction

  task automatic tick(input logic d);
    logic       bnd;
    logic [1:0] es;
    logic [6:0] g;
    logic [7:0] o;
    data_clk = d;
    bnd = m_prev & ~d;
    m_prev = d;
    if (bnd) begin
      m_single = (chan_mode == 2'b01);
      m_order  = cidx[4:2];
      m_sc     = cidx[1:0];
      m_act    = 1'b1;
      m_step   = 0;
    end else if (m_act && m_step < 2) begin
      m_step++;
    end
    if (!m_act)        es = 2'd0;
    else if (m_single) es = (m_sc == 2'd1) ? 2'd1 : (m_sc == 2'd2) ? 2'd2 : 2'd0;
    else               es = ref_order(m_order, m_step);
    g = (es == 2'd1) ? g_g : (es == 2'd2) ? g_b : g_r;
    o = (es == 2'd1) ? o_g : (es == 2'd2) ? o_b : o_r;
    exp_q.push_back({es, bnd, g[6:5], g[4:0], o});
    tag_q.push_back(cur_tag);
    @(negedge clk);
  endtask

  task automatic pixel(input int n);
    tick(1'b1);
    for (int i = 1; i < n; i++) tick(1'b0);
  endtask

  // monitor: compare after each rising edge, away from the edge
  initial begin
    logic [17:0] e;
    logic [17:0] a;
    string t;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {sel, pstart, coarse, fine, offs};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s sel/start/coarse/fine/off got %0d/%0d/%0d/%0d/%h exp %0d/%0d/%0d/%0d/%h",
                   t, a[17:16], a[15], a[14:13], a[12:8], a[7:0],
                   e[17:16], e[15], e[14:13], e[12:8], e[7:0]);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; data_clk = 1'b0; chan_mode = 2'b00; cidx = 5'd0;
    g_r = 7'h15; g_g = 7'h4A; g_b = 7'h7F;
    o_r = 8'h80; o_g = 8'h11; o_b = 8'hEE;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if ({sel, pstart, coarse, fine, offs} !== 18'd0) begin
      errors++;
      $display("FAIL R1 reset outputs got %h exp 0", {sel, pstart, coarse, fine, offs});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 no pixel start before a high sample; codes track red (R9)
    cur_tag = "R2_idle"; tick(1'b0); tick(1'b0);

    // R3, R4, R9: all six orders, pixel of 5 conversions exercises hold
    cur_tag = "R3_orders";
    for (int k = 0; k < 6; k++) begin
      cidx = 5'(k << 2);
      pixel(5);
    end
    // R5 reserved order codes
    cur_tag = "R5_reserved";
    cidx = 5'b11000; pixel(4);
    cidx = 5'b11100; pixel(4);
    // R7 other mode values run three-channel
    cur_tag = "R7_modes";
    chan_mode = 2'b10; cidx = 5'b01100; pixel(4);
    chan_mode = 2'b11; cidx = 5'b10000; pixel(4);
    // R6 single-channel colours including reserved
    cur_tag = "R6_single";
    chan_mode = 2'b01;
    for (int k = 0; k < 4; k++) begin
      cidx = 5'(k) | 5'b10100;
      pixel(4);
    end
    // R8 mid-pixel rewrites wait for the next start
    cur_tag = "R8_midpixel";
    cidx = 5'b00010;
    tick(1'b1); tick(1'b0);
    chan_mode = 2'b00; cidx = 5'b10100;
    tick(1'b0); tick(1'b0); tick(1'b0);
    // R8 same-cycle rewrite applies to that pixel
    tick(1'b1);
    cidx = 5'b01000;
    tick(1'b0); tick(1'b0); tick(1'b0);
    // R9 live gain change mid-pixel
    cur_tag = "R9_live";
    cidx = 5'b00000;
    tick(1'b1); tick(1'b0);
    g_g = 7'h33; o_g = 8'h5C; g_b = 7'h20;
    tick(1'b0); tick(1'b0);
    // R10 short pixels restart the order
    cur_tag = "R10_restart";
    cidx = 5'b01100;
    tick(1'b1); tick(1'b0); tick(1'b1); tick(1'b0); tick(1'b0);
    cidx = 5'b10000;
    tick(1'b1); tick(1'b0); tick(1'b0); tick(1'b1); tick(1'b0); tick(1'b0); tick(1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule